// File: doc/BRIEF.md
# GPIO Interrupt Sense and Pending Unit

This block watches a 32-pin input port and turns pin activity into interrupt requests. Each pin has a 4-bit trigger code. The code selects a rising edge, a falling edge, both edges, a high level or a low level. A mode bit picks a short or a longer sampling path. A detected event on a pin whose gate bit is open is latched into a sticky pending bit. Software clears a pending bit by writing a 1 to it.

Pending bits pass through a mask-enable register before they reach the outputs. That register is changed only through a set strobe address and a clear strobe address. The masked pending word is readable, and it drives two interrupt lines: one covers pins 0 to 15 and the other covers pins 16 to 31. Register access uses a simple write port and a read port with a combinational read. The trigger codes sit in a second address window at byte offsets 0x40 to 0x4C.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, the gate (0x14), mask-enable (0x1C), raw pending (0x20), masked pending (0x24) and every trigger register (0x40, 0x44, 0x48, 0x4C) read 0, and both interrupt outputs are low.
- R2: Pin n's trigger code is held in the register at 0x40 + 4*(n>>3), bits (n&7)*4+3 down to (n&7)*4. It reads back as written.
- R3: Trigger code bits 2:0 select the event. 0 latches on a 0-to-1 change of the pin, 1 on a 1-to-0 change, and 4 on either change. An edge that goes the other way does not latch.
- R4: Code 2 latches while the pin is 1 and code 3 while it is 0. A clear written while the level is still active leaves the bit reading 1 on the next cycle.
- R5: Codes 5, 6 and 7 in bits 2:0 never latch a pending bit.
- R6: The gate register at 0x14 is read/write. A pin whose gate bit is 0 never latches a new pending bit.
- R7: Writing 1s to 0x18 sets mask-enable bits, and writing 1s to 0x1C clears them. Zero bits leave those bits unchanged. Reading 0x1C returns the mask-enable state.
- R8: 0x20 reads the raw pending bits. 0x24 reads the pending bits ANDed with the mask-enable bits.
- R9: Writing 1 to a bit of 0x28 clears that pending bit, and writing 0 has no effect. An event on the same pin in the same cycle as the clear leaves the bit set.
- R10: irq_lo is high exactly when any of bits 15:0 of the masked pending word is set. irq_hi is high exactly when any of bits 31:16 is set.
- R11: With trigger bit 3 = 1, a pin change sampled at clock edge k shows in raw pending after edge k+2. With bit 3 = 0, it shows after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | 32 | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 7 | Read byte address |
| rd_data | output | 32 | Read data, combinational on rd_addr |
| irq_lo | output | 1 | Interrupt for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt for pins 16 to 31 |

## Verification
A table of trigger codes is paired with pin transitions: a rise, a fall, and no change. Each pairing uses a different pin, spread over all four trigger registers. These pairings tell the edge codes apart from the level codes and from the dead codes, and they show that each edge code ignores the opposite edge. Directed patterns then measure how many cycles a change takes to reach pending in each sampling mode. They also show that the gate blocks a level that is held active. Finally, they place a clear in the same cycle as an edge and in the same cycle as an active level, and compare the low-half and high-half interrupt lines as mask bits are set and cleared one at a time.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    // Register byte offsets
    localparam int OFS_GATE     = 'h14;
    localparam int OFS_MSK_SET  = 'h18;
    localparam int OFS_MSK_CLR  = 'h1C;
    localparam int OFS_RAW      = 'h20;
    localparam int OFS_MASKED   = 'h24;
    localparam int OFS_ACK      = 'h28;
    localparam int OFS_TRIG     = 'h40;

    // Trigger selection in bits 2:0 of a pin's code
    typedef enum logic [2:0] {
        TRG_RISE = 3'd0,
        TRG_FALL = 3'd1,
        TRG_HIGH = 3'd2,
        TRG_LOW  = 3'd3,
        TRG_ANY  = 3'd4
    } trig_sel_e;

    localparam int CODE_W    = 4;
    localparam int FAST_BIT  = 3;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign d_out = st_q.stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPIN-1:0]              lvl,
    input  logic [NPIN-1:0][CODE_W-1:0]  code,
    output logic [NPIN-1:0]              trig
);
    typedef struct packed {
        logic [NPIN-1:0] dly1;
        logic [NPIN-1:0] dly2;
    } hist_t;

    hist_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.dly1 = lvl;
        st_d.dly2 = st_q.dly1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic now_v, old_v;
        assign now_v = code[p][FAST_BIT] ? lvl[p]        : st_q.dly1[p];
        assign old_v = code[p][FAST_BIT] ? st_q.dly1[p]  : st_q.dly2[p];
        always_comb begin
            case (code[p][2:0])
                TRG_RISE: trig[p] = now_v & ~old_v;
                TRG_FALL: trig[p] = ~now_v & old_v;
                TRG_HIGH: trig[p] = now_v;
                TRG_LOW:  trig[p] = ~now_v;
                TRG_ANY:  trig[p] = now_v ^ old_v;
                default:  trig[p] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPIN   = 32,
    parameter int ADDR_W = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPIN-1:0]              trig,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [NPIN-1:0]              wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [NPIN-1:0]              rd_data,
    output logic [NPIN-1:0][CODE_W-1:0]  code,
    output logic                         irq_lo,
    output logic                         irq_hi
);
    localparam int PER_REG = NPIN / CODE_W > 0 ? 32 / CODE_W : 1;
    localparam int NREG    = NPIN / PER_REG;
    localparam int HALF    = NPIN / 2;

    typedef struct packed {
        logic [NPIN-1:0]             gate;
        logic [NPIN-1:0]             msk;
        logic [NPIN-1:0]             pend;
        logic [NPIN-1:0][CODE_W-1:0] code;
    } regs_t;

    regs_t st_d, st_q;
    logic [NPIN-1:0] set_v, clrm_v, ack_v, masked;

    always_comb begin
        st_d   = st_q;
        set_v  = (wr_en && wr_addr == ADDR_W'(OFS_MSK_SET)) ? wr_data : '0;
        clrm_v = (wr_en && wr_addr == ADDR_W'(OFS_MSK_CLR)) ? wr_data : '0;
        ack_v  = (wr_en && wr_addr == ADDR_W'(OFS_ACK))     ? wr_data : '0;
        if (wr_en && wr_addr == ADDR_W'(OFS_GATE)) st_d.gate = wr_data;
        st_d.msk  = (st_q.msk | set_v) & ~clrm_v;
        st_d.pend = (st_q.pend & ~ack_v) | (trig & st_q.gate);
        for (int r = 0; r < NREG; r++) begin
            if (wr_en && wr_addr == ADDR_W'(OFS_TRIG + 4 * r)) begin
                for (int j = 0; j < PER_REG; j++) begin
                    st_d.code[r*PER_REG+j] = wr_data[j*CODE_W +: CODE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign masked = st_q.pend & st_q.msk;
    assign code   = st_q.code;
    assign irq_lo = |masked[HALF-1:0];
    assign irq_hi = |masked[NPIN-1:HALF];

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(OFS_GATE):    rd_data = st_q.gate;
            ADDR_W'(OFS_MSK_CLR): rd_data = st_q.msk;
            ADDR_W'(OFS_RAW):     rd_data = st_q.pend;
            ADDR_W'(OFS_MASKED):  rd_data = masked;
            default:              rd_data = '0;
        endcase
        for (int r = 0; r < NREG; r++) begin
            if (rd_addr == ADDR_W'(OFS_TRIG + 4 * r)) begin
                for (int j = 0; j < PER_REG; j++) begin
                    rd_data[j*CODE_W +: CODE_W] = st_q.code[r*PER_REG+j];
                end
            end
        end
    end

    // Assertion helper: pins carrying an unused trigger code
    logic [NPIN-1:0] dead_v;
    always_comb begin
        for (int i = 0; i < NPIN; i++) dead_v[i] = (st_q.code[i][2:0] > 3'd4);
    end

    // R6
    gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.pend & ~$past(st_q.pend) & ~$past(st_q.gate)) == '0));

    // R5
    dead_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.pend & ~$past(st_q.pend) & $past(dead_v)) == '0));

    // R7
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(OFS_MSK_SET))
        |=> ((st_q.msk & $past(wr_data)) == $past(wr_data)));

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(OFS_ACK))
        |=> ((st_q.pend & $past(wr_data) & ~$past(trig & st_q.gate)) == '0));

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo || irq_hi) |-> (st_q.msk != '0 && st_q.pend != '0));
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
    import gpio_irq_pkg::*;
#(
    parameter int NPIN        = 32,
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPIN-1:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NPIN-1:0]   rd_data,
    output logic              irq_lo,
    output logic              irq_hi
);
    logic [NPIN-1:0]             lvl;
    logic [NPIN-1:0]             trig;
    logic [NPIN-1:0][CODE_W-1:0] code;

    gpio_irq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pin_in), .d_out(lvl)
    );

    gpio_irq_detect #(.NPIN(NPIN)) u_det (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .code(code), .trig(trig)
    );

    gpio_irq_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .trig(trig),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .code(code),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );
endmodule

// File: tb/sim_gpio_irq_sense.sv
`timescale 1ns/1ps
module sim_gpio_irq_sense;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [6:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_lo, irq_hi;

    int errs = 0;
    int nchk = 0;
    logic [3:0] sh [32];
    logic [31:0] v;

    always #2.5 clk = ~clk;

    gpio_irq_sense u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // {code[3:0], start level, end level, expected pending}
    localparam logic [6:0] VEC [0:14] = '{
        7'b1000_0_1_1, 7'b1000_1_0_0, 7'b1000_0_0_0,
        7'b1001_1_0_1, 7'b1001_0_1_0,
        7'b1010_0_1_1, 7'b1010_0_0_0,
        7'b1011_1_0_1, 7'b1011_1_1_0,
        7'b1100_0_1_1, 7'b1100_1_0_1, 7'b1100_1_1_0,
        7'b1101_0_1_0, 7'b1110_1_0_0, 7'b1111_0_1_0
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic set_code(input int p, input logic [3:0] c);
        logic [31:0] d = '0;
        sh[p] = c;
        for (int j = 0; j < 8; j++) d[j*4 +: 4] = sh[(p/8)*8 + j];
        wr(7'h40 + 7'(4 * (p / 8)), d);
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errs, nchk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; nchk++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) sh[i] = 4'h0;
        waitn(3);
        rst_n = 1'b1;

        // R1: reset state
        rd(7'h14, v); chk("R1 gate", v, 0);
        rd(7'h1C, v); chk("R1 mask", v, 0);
        rd(7'h20, v); chk("R1 raw", v, 0);
        rd(7'h24, v); chk("R1 masked", v, 0);
        for (int r = 0; r < 4; r++) begin
            rd(7'h40 + 7'(4 * r), v); chk("R1 trig", v, 0);
        end
        chk("R1 irq", {30'd0, irq_hi, irq_lo}, 0);

        // R2: field layout
        wr(7'h44, 32'h89AB_CDEF);
        rd(7'h44, v); chk("R2 readback", v, 32'h89AB_CDEF);
        wr(7'h44, 32'h0);
        set_code(13, 4'hB);
        rd(7'h44, v); chk("R2 pin13 field", v, 32'h00B0_0000);
        set_code(13, 4'h0);

        // R3 R4 R5: table walk
        for (int i = 0; i < 15; i++) begin
            int p = (i * 5) % 32;
            wr(7'h14, 0);
            @(negedge clk) pin_in[p] = VEC[i][2];
            set_code(p, VEC[i][6:3]);
            waitn(4);
            wr(7'h14, 32'h1 << p);
            wr(7'h28, 32'hFFFF_FFFF);
            @(negedge clk) pin_in[p] = VEC[i][1];
            waitn(5);
            rd(7'h20, v);
            chk($sformatf("R3/R4/R5 vec%0d code=%h", i, VEC[i][6:3]), {31'd0, v[p]}, {31'd0, VEC[i][0]});
            set_code(p, 4'h0);
            @(negedge clk) pin_in[p] = 1'b0;
        end
        wr(7'h14, 0);
        waitn(4);
        wr(7'h28, 32'hFFFF_FFFF);

        // R11: latency in both sampling modes
        set_code(3, 4'h8);
        wr(7'h14, 32'h8);
        @(negedge clk);
        rd_addr = 7'h20;
        pin_in[3] = 1'b1;
        @(posedge clk); @(posedge clk); #1 chk("R11 fast k+1", {31'd0, rd_data[3]}, 0);
        @(posedge clk); #1 chk("R11 fast k+2", {31'd0, rd_data[3]}, 1);
        @(negedge clk) pin_in[3] = 1'b0;
        set_code(3, 4'h0);
        waitn(4);
        wr(7'h28, 32'h8);
        @(negedge clk);
        rd_addr = 7'h20;
        pin_in[3] = 1'b1;
        @(posedge clk); @(posedge clk); @(posedge clk); #1 chk("R11 slow k+2", {31'd0, rd_data[3]}, 0);
        @(posedge clk); #1 chk("R11 slow k+3", {31'd0, rd_data[3]}, 1);

        // R9: zeros in ack ignored, ones clear
        wr(7'h28, 32'h0);
        rd(7'h20, v); chk("R9 zero ack", {31'd0, v[3]}, 1);
        wr(7'h28, 32'h8);
        rd(7'h20, v); chk("R9 one ack", {31'd0, v[3]}, 0);

        // R9: edge in same cycle as ack
        set_code(20, 4'hC);
        wr(7'h14, 32'h0010_0008);
        @(negedge clk) pin_in[20] = 1'b1;
        waitn(4);
        rd(7'h20, v); chk("R9 setup", {31'd0, v[20]}, 1);
        @(negedge clk) pin_in[20] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'h28; wr_data = 32'h0010_0000;
        @(negedge clk); wr_en = 1'b0;
        rd(7'h20, v); chk("R9 edge beats ack", {31'd0, v[20]}, 1);
        wr(7'h28, 32'h0010_0000);
        rd(7'h20, v); chk("R9 ack after edge", {31'd0, v[20]}, 0);

        // R4: active level re-sets after ack
        set_code(17, 4'hA);
        wr(7'h14, 32'h0002_0000);
        @(negedge clk) pin_in[17] = 1'b1;
        waitn(4);
        wr(7'h28, 32'h0002_0000);
        rd(7'h20, v); chk("R4 level re-set", {31'd0, v[17]}, 1);
        @(negedge clk) pin_in[17] = 1'b0;
        waitn(4);
        wr(7'h28, 32'h0002_0000);
        rd(7'h20, v); chk("R4 inactive ack", {31'd0, v[17]}, 0);

        // R6: gate blocks a held level
        set_code(9, 4'hA);
        wr(7'h14, 32'h0);
        @(negedge clk) pin_in[9] = 1'b1;
        waitn(5);
        rd(7'h20, v); chk("R6 gated off", {31'd0, v[9]}, 0);
        wr(7'h14, 32'h0000_0200);
        rd(7'h14, v); chk("R6 gate readback", v, 32'h0000_0200);
        waitn(2);
        rd(7'h20, v); chk("R6 gated on", {31'd0, v[9]}, 1);

        // R7 R8 R10: mask and outputs; pins 9 and 17 held at active level
        set_code(17, 4'hA);
        wr(7'h14, 32'h0002_0200);
        @(negedge clk) pin_in[17] = 1'b1;
        waitn(5);
        chk("R10 all masked", {30'd0, irq_hi, irq_lo}, 0);
        wr(7'h18, 32'h0000_0200);
        rd(7'h1C, v); chk("R7 set", v, 32'h0000_0200);
        rd(7'h24, v); chk("R8 masked lo", v, 32'h0000_0200);
        rd(7'h20, v); chk("R8 raw", v, 32'h0002_0200);
        chk("R10 lo only", {30'd0, irq_hi, irq_lo}, 2'b01);
        wr(7'h18, 32'h0002_0000);
        rd(7'h1C, v); chk("R7 set keeps", v, 32'h0002_0200);
        chk("R10 both", {30'd0, irq_hi, irq_lo}, 2'b11);
        wr(7'h1C, 32'h0000_0200);
        rd(7'h1C, v); chk("R7 clear", v, 32'h0002_0000);
        rd(7'h24, v); chk("R8 masked hi", v, 32'h0002_0000);
        chk("R10 hi only", {30'd0, irq_hi, irq_lo}, 2'b10);

        summary();
        $finish;
    end
endmodule